// File: doc/BRIEF.md
# Wavefront Integer Add/Subtract Unit with Saturation

This block performs unsigned integer addition and subtraction on every lane of a 64-lane vector in parallel. One strobe presents two operand vectors, an execution mask that says which lanes take part, a 64-bit carry-in mask, an operation code and a clamp flag. One clock later the block presents the lane results, a per-lane write enable and a 64-bit carry-out mask. In the carry-out mask, bit `i` holds the carry or borrow of lane `i`.

The operations come in 32-bit and 16-bit widths. The 32-bit forms are forward subtract, reverse subtract (second operand minus first), and variants that consume a carry or borrow bit. Each lane takes that bit from the carry-in mask at its own lane index. When the clamp flag is set, adds saturate at the all-ones value of their width and subtracts that wrap saturate at zero. Lanes outside the execution mask keep their previous result and report a zero carry bit.

Top module: `simd_intaddsub`

## Requirements
- R1: Op code 0x0 (add) forms the 33-bit sum of the zero-extended lane operands. The result is the low 32 bits and the carry-out bit is bit 32 of the sum.
- R2: Op code 0x3 (add with carry) adds `cin_mask[i]` into the sum of lane `i`. Its carry-out rule is the same as R1.
- R3: Op code 0x1 computes a − b and op code 0x2 computes b − a, both modulo 2^32. The carry-out bit is 1 exactly when the true difference is negative (a borrow).
- R4: Op codes 0x4 (a − b − cin) and 0x5 (b − a − cin) subtract `cin_mask[i]` as a borrow-in. Borrow-out follows R3.
- R5: With `clamp` set, a 32-bit add whose 33-bit sum exceeds 0xFFFFFFFF gives 0xFFFFFFFF. The carry-out bit is still reported.
- R6: With `clamp` set, a 32-bit subtract of any form (0x1, 0x2, 0x4, 0x5) that borrows gives 0. The borrow-out bit is still reported.
- R7: Op code 0x6 adds the low 16 bits of both operands. Without clamp the result is the low 16 bits of the sum; with clamp the sum saturates at 0xFFFF. Result bits 31:16 are 0 and the carry-out bit is 0.
- R8: Op codes 0x7 (a − b) and 0x8 (b − a) take the signed difference of the low 16 bits of the operands. Without clamp the result is its low 16 bits; with clamp a negative difference gives 0. Bits 31:16 are 0, the carry-out bit is 0, and the carry-in mask is ignored.
- R9: A lane whose `exec_mask` bit is 0 keeps its previous result and drives a 0 into its carry-out bit.
- R10: One cycle after a strobe, `out_vld` is 1 and `wr_en` equals the strobed `exec_mask`. In a cycle after no strobe, `out_vld` and `wr_en` are 0 and the results and carry-out mask hold their values.
- R11: A synchronous reset clears `out_vld`, `wr_en`, `cout_mask` and all lane results to 0.
- R12: Op codes 0x9 to 0xF give a 0 result and a 0 carry-out bit in active lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Input strobe |
| op | input | 4 | Operation code |
| clamp | input | 1 | Saturate results |
| src_a | input | 2048 | First operand, lane `i` at bits [32i+31:32i] |
| src_b | input | 2048 | Second operand, same packing |
| exec_mask | input | 64 | Active-lane mask |
| cin_mask | input | 64 | Carry/borrow-in bit per lane |
| out_vld | output | 1 | Results valid |
| wr_en | output | 64 | Per-lane write enable |
| res | output | 2048 | Lane results, same packing as operands |
| cout_mask | output | 64 | Carry/borrow-out bit per lane |

## Verification
The bench aims at the wrap points of the operations:
- all-ones plus one, where a unit without saturation would return 0 and a unit with a misplaced carry bit would miss the carry;
- equal operands with a borrow-in, which must borrow and clamp to 0, where a design that forgot the borrow-in would return 0 with no borrow flag;
- 16-bit operands with junk in their upper halves, which exposes a unit that fails to mask them;
- reverse subtracts, which catch swapped operands.

Sparse execution masks applied with operands that overflow would show up an inactive lane that leaks a carry bit or overwrites its held result.

// File: rtl/simd_as_pkg.sv
package simd_as_pkg;
  typedef enum logic [3:0] {
    OP_ADD     = 4'h0,
    OP_SUB     = 4'h1,
    OP_RSUB    = 4'h2,
    OP_ADDC    = 4'h3,
    OP_SUBB    = 4'h4,
    OP_RSUBB   = 4'h5,
    OP_ADD16   = 4'h6,
    OP_SUB16   = 4'h7,
    OP_RSUB16  = 4'h8
  } op_e;
endpackage

// File: rtl/simd_as_lane.sv
module simd_as_lane
  import simd_as_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op_i,
  input  logic         clamp_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  localparam int HW = W / 2;

  function automatic logic [W:0] wide_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + (W+1)'(c);
  endfunction

  function automatic logic [W:0] wide_sub(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic c);
    return {1'b0, x} - {1'b0, y} - (W+1)'(c);
  endfunction

  function automatic logic [HW:0] half_add(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x[HW-1:0]} + {1'b0, y[HW-1:0]};
  endfunction

  function automatic logic [HW:0] half_sub(input logic [W-1:0] x, input logic [W-1:0] y);
    return {1'b0, x[HW-1:0]} - {1'b0, y[HW-1:0]};
  endfunction

  // saturating selects: top bit of the wide value flags overflow or borrow
  function automatic logic [W-1:0] sat_up(input logic [W:0] w);
    return w[W] ? '1 : w[W-1:0];
  endfunction

  function automatic logic [W-1:0] sat_zero(input logic [W:0] w);
    return w[W] ? '0 : w[W-1:0];
  endfunction

  op_e          op_c;
  logic [W:0]   wide_w;
  logic [HW:0]  half_w;
  logic         full_op;
  logic         half_op;
  logic         is_add;
  logic         wrap_ev;

  assign op_c = op_e'(op_i);

  always_comb begin
    wide_w  = '0;
    half_w  = '0;
    full_op = 1'b0;
    half_op = 1'b0;
    is_add  = 1'b0;
    case (op_c)
      OP_ADD:    begin wide_w = wide_add(a_i, b_i, 1'b0);  full_op = 1'b1; is_add = 1'b1; end
      OP_ADDC:   begin wide_w = wide_add(a_i, b_i, cin_i); full_op = 1'b1; is_add = 1'b1; end
      OP_SUB:    begin wide_w = wide_sub(a_i, b_i, 1'b0);  full_op = 1'b1; end
      OP_RSUB:   begin wide_w = wide_sub(b_i, a_i, 1'b0);  full_op = 1'b1; end
      OP_SUBB:   begin wide_w = wide_sub(a_i, b_i, cin_i); full_op = 1'b1; end
      OP_RSUBB:  begin wide_w = wide_sub(b_i, a_i, cin_i); full_op = 1'b1; end
      OP_ADD16:  begin half_w = half_add(a_i, b_i); half_op = 1'b1; is_add = 1'b1; end
      OP_SUB16:  begin half_w = half_sub(a_i, b_i); half_op = 1'b1; end
      OP_RSUB16: begin half_w = half_sub(b_i, a_i); half_op = 1'b1; end
      default:   begin end
    endcase
  end

  // named event: the wide result left the representable range of its width
  assign wrap_ev = full_op ? wide_w[W] : (half_op ? half_w[HW] : 1'b0);

  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    if (full_op) begin
      cout_o = wide_w[W];
      if (clamp_i) res_o = is_add ? sat_up(wide_w) : sat_zero(wide_w);
      else         res_o = wide_w[W-1:0];
    end else if (half_op) begin
      if (clamp_i && half_w[HW]) res_o[HW-1:0] = is_add ? '1 : '0;
      else                       res_o[HW-1:0] = half_w[HW-1:0];
    end
  end

  // R5
  add_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (clamp_i && is_add && full_op && wrap_ev) |-> (res_o == '1));

  // R6
  sub_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (clamp_i && !is_add && full_op && wrap_ev) |-> (res_o == '0));

  // R7
  half_upper_chk: assert property (@(posedge clk) disable iff (rst)
    half_op |-> (res_o[W-1:HW] == '0 && !cout_o));

  // R8
  half_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (clamp_i && half_op && !is_add && wrap_ev) |-> (res_o == '0));
endmodule

// File: rtl/simd_as_ostage.sv
module simd_as_ostage #(
  parameter int LANES = 64,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld_i,
  input  logic [LANES-1:0]   exec_i,
  input  logic [LANES*W-1:0] lane_res_i,
  input  logic [LANES-1:0]   lane_cout_i,
  output logic               out_vld_o,
  output logic [LANES-1:0]   wr_en_o,
  output logic [LANES*W-1:0] res_o,
  output logic [LANES-1:0]   cout_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld_o <= 1'b0;
      wr_en_o   <= '0;
      cout_o    <= '0;
    end else begin
      out_vld_o <= in_vld_i;
      wr_en_o   <= in_vld_i ? exec_i : '0;
      if (in_vld_i) cout_o <= lane_cout_i & exec_i;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane_q
    always_ff @(posedge clk) begin
      if (rst)                         res_o[g*W +: W] <= '0;
      else if (in_vld_i && exec_i[g])  res_o[g*W +: W] <= lane_res_i[g*W +: W];
    end

    // R9
    idle_lane_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (in_vld_i && !exec_i[g]) |=> $stable(res_o[g*W +: W]));
  end

  // R9
  dead_carry_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld_o |-> ((cout_o & ~wr_en_o) == '0));

  // R10
  quiet_wren_chk: assert property (@(posedge clk) disable iff (rst)
    !out_vld_o |-> (wr_en_o == '0));

  // R10
  vld_origin_chk: assert property (@(posedge clk) disable iff (rst)
    out_vld_o |-> $past(in_vld_i));
endmodule

// File: rtl/simd_intaddsub.sv
module simd_intaddsub #(
  parameter int LANES = 64,
  parameter int W     = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_vld,
  input  logic [3:0]         op,
  input  logic               clamp,
  input  logic [LANES*W-1:0] src_a,
  input  logic [LANES*W-1:0] src_b,
  input  logic [LANES-1:0]   exec_mask,
  input  logic [LANES-1:0]   cin_mask,
  output logic               out_vld,
  output logic [LANES-1:0]   wr_en,
  output logic [LANES*W-1:0] res,
  output logic [LANES-1:0]   cout_mask
);
  logic [LANES*W-1:0] lane_res;
  logic [LANES-1:0]   lane_cout;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    simd_as_lane #(.W(W)) i_lane (
      .clk     (clk),
      .rst     (rst),
      .op_i    (op),
      .clamp_i (clamp),
      .a_i     (src_a[g*W +: W]),
      .b_i     (src_b[g*W +: W]),
      .cin_i   (cin_mask[g]),
      .res_o   (lane_res[g*W +: W]),
      .cout_o  (lane_cout[g])
    );
  end

  simd_as_ostage #(.LANES(LANES), .W(W)) i_ostage (
    .clk         (clk),
    .rst         (rst),
    .in_vld_i    (in_vld),
    .exec_i      (exec_mask),
    .lane_res_i  (lane_res),
    .lane_cout_i (lane_cout),
    .out_vld_o   (out_vld),
    .wr_en_o     (wr_en),
    .res_o       (res),
    .cout_o      (cout_mask)
  );
endmodule

// File: tb/test_simd_intaddsub.sv
`timescale 1ns/1ps
module test_simd_intaddsub;
  localparam int L = 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_vld = 1'b0;
  logic [3:0]    op = '0;
  logic          clamp = 1'b0;
  logic [L*32-1:0] src_a = '0, src_b = '0;
  logic [L-1:0]  exec_mask = '0, cin_mask = '0;
  logic          out_vld;
  logic [L-1:0]  wr_en, cout_mask;
  logic [L*32-1:0] res;

  logic [31:0]   a_arr [L];
  logic [31:0]   b_arr [L];
  logic [31:0]   exp_res [L];
  logic [L-1:0]  exp_cout, exp_wr;
  int            n_vec = 0, n_bad = 0;

  always #10 clk = ~clk;

  simd_intaddsub i_simd_intaddsub (
    .clk(clk), .rst(rst), .in_vld(in_vld), .op(op), .clamp(clamp),
    .src_a(src_a), .src_b(src_b), .exec_mask(exec_mask), .cin_mask(cin_mask),
    .out_vld(out_vld), .wr_en(wr_en), .res(res), .cout_mask(cout_mask)
  );

  // independent lane model in 64-bit signed arithmetic
  function automatic void ref_lane(input logic [3:0] o, input logic cl,
                                   input logic [31:0] a, input logic [31:0] b,
                                   input logic ci, output logic [31:0] r, output logic c);
    longint x, y, t, k;
    x = longint'({32'd0, a});
    y = longint'({32'd0, b});
    k = ci ? 64'd1 : 64'd0;
    r = '0; c = 1'b0;
    case (o)
      4'h0, 4'h3: begin
        t = x + y + ((o == 4'h3) ? k : 0);
        c = (t > 64'h0000_0000_FFFF_FFFF);
        r = (cl && c) ? 32'hFFFF_FFFF : t[31:0];
      end
      4'h1, 4'h2, 4'h4, 4'h5: begin
        t = (o == 4'h1 || o == 4'h4) ? (x - y) : (y - x);
        if (o == 4'h4 || o == 4'h5) t = t - k;
        c = (t < 0);
        r = (cl && c) ? 32'd0 : t[31:0];
      end
      4'h6: begin
        t = (x & 64'hFFFF) + (y & 64'hFFFF);
        r = (cl && t > 65535) ? 32'h0000_FFFF : {16'h0, t[15:0]};
      end
      4'h7, 4'h8: begin
        t = (o == 4'h7) ? ((x & 64'hFFFF) - (y & 64'hFFFF)) : ((y & 64'hFFFF) - (x & 64'hFFFF));
        r = (cl && t < 0) ? 32'd0 : {16'h0, t[15:0]};
      end
      default: begin r = '0; c = 1'b0; end
    endcase
  endfunction

  task automatic compare(input string req);
    logic bad;
    bad = 1'b0;
    n_vec++;
    if (out_vld !== 1'b1 || wr_en !== exp_wr) begin
      $display("FAIL %s vld/wr_en actual %b/%h expected 1/%h", req, out_vld, wr_en, exp_wr);
      bad = 1'b1;
    end
    if (cout_mask !== exp_cout) begin
      $display("FAIL %s cout_mask actual %h expected %h", req, cout_mask, exp_cout);
      bad = 1'b1;
    end
    for (int i = 0; i < L; i++) begin
      if (!bad && res[i*32 +: 32] !== exp_res[i]) begin
        $display("FAIL %s lane %0d res actual %h expected %h", req, i, res[i*32 +: 32], exp_res[i]);
        bad = 1'b1;
      end
    end
    if (bad) n_bad++;
  endtask

  // call at a negedge; strobes one vector and checks it one cycle later
  task automatic apply(input logic [3:0] o, input logic cl, input logic [L-1:0] ex,
                       input logic [L-1:0] ci, input string req);
    logic [31:0] r;
    logic c;
    op = o; clamp = cl; exec_mask = ex; cin_mask = ci; in_vld = 1'b1;
    for (int i = 0; i < L; i++) begin
      src_a[i*32 +: 32] = a_arr[i];
      src_b[i*32 +: 32] = b_arr[i];
      ref_lane(o, cl, a_arr[i], b_arr[i], ci[i], r, c);
      if (ex[i]) exp_res[i] = r;
      exp_cout[i] = ex[i] & c;
    end
    exp_wr = ex;
    @(negedge clk);
    in_vld = 1'b0;
    compare(req);
  endtask

  task automatic fill_rand();
    for (int i = 0; i < L; i++) begin
      a_arr[i] = $urandom;
      b_arr[i] = $urandom;
    end
  endtask

  task automatic check_cleared(input string req);
    logic bad;
    bad = 1'b0;
    n_vec++;
    if (out_vld !== 1'b0 || wr_en !== '0 || cout_mask !== '0 || res !== '0) begin
      $display("FAIL %s cleared state actual vld=%b wr=%h cout=%h res_nz=%b expected all zero",
               req, out_vld, wr_en, cout_mask, |res);
      bad = 1'b1;
    end
    if (bad) n_bad++;
    for (int i = 0; i < L; i++) exp_res[i] = '0;
    exp_cout = '0;
  endtask

  task automatic t_reset();  // R11
    check_cleared("R11");
  endtask

  task automatic t_add32();  // R1, R5
    fill_rand();
    a_arr[0] = 32'hFFFF_FFFF; b_arr[0] = 32'd1;
    a_arr[1] = 32'd0;         b_arr[1] = 32'd0;
    a_arr[2] = 32'h8000_0000; b_arr[2] = 32'h8000_0000;
    apply(4'h0, 1'b0, '1, '0, "R1");
    apply(4'h0, 1'b1, '1, '0, "R5");
  endtask

  task automatic t_addc();  // R2
    fill_rand();
    a_arr[3] = 32'hFFFF_FFFF; b_arr[3] = 32'd0;
    apply(4'h3, 1'b0, '1, {$urandom, $urandom} | 64'h8, "R2");
    apply(4'h3, 1'b0, '1, 64'hFFFF_FFFF_FFFF_FFFF, "R2");
    apply(4'h3, 1'b1, '1, {$urandom, $urandom} | 64'h8, "R5");
  endtask

  task automatic t_sub();  // R3, R6
    fill_rand();
    a_arr[0] = 32'd5; b_arr[0] = 32'd5;
    a_arr[1] = 32'd0; b_arr[1] = 32'd1;
    a_arr[2] = 32'd7; b_arr[2] = 32'd3;
    apply(4'h1, 1'b0, '1, '0, "R3");
    apply(4'h2, 1'b0, '1, '0, "R3");
    apply(4'h1, 1'b1, '1, '0, "R6");
    apply(4'h2, 1'b1, '1, '0, "R6");
  endtask

  task automatic t_subb();  // R4, R6
    fill_rand();
    a_arr[0] = 32'd9; b_arr[0] = 32'd9;
    a_arr[1] = 32'd0; b_arr[1] = 32'd0;
    apply(4'h4, 1'b0, '1, {$urandom, $urandom} | 64'h3, "R4");
    apply(4'h5, 1'b0, '1, {$urandom, $urandom} | 64'h3, "R4");
    apply(4'h4, 1'b1, '1, {$urandom, $urandom} | 64'h3, "R6");
    apply(4'h5, 1'b1, '1, {$urandom, $urandom} | 64'h3, "R6");
  endtask

  task automatic t_add16();  // R7
    fill_rand();
    a_arr[0] = 32'hABCD_FFFF; b_arr[0] = 32'h1234_0001;
    a_arr[1] = 32'hFFFF_0000; b_arr[1] = 32'hFFFF_0000;
    apply(4'h6, 1'b0, '1, '1, "R7");
    apply(4'h6, 1'b1, '1, '1, "R7");
  endtask

  task automatic t_sub16();  // R8
    fill_rand();
    a_arr[0] = 32'h7777_0003; b_arr[0] = 32'h0000_0004;
    a_arr[1] = 32'h0000_0010; b_arr[1] = 32'hFFFF_0010;
    apply(4'h7, 1'b0, '1, '1, "R8");
    apply(4'h8, 1'b0, '1, '1, "R8");
    apply(4'h7, 1'b1, '1, '1, "R8");
    apply(4'h8, 1'b1, '1, '1, "R8");
  endtask

  task automatic t_inactive();  // R9
    for (int i = 0; i < L; i++) begin
      a_arr[i] = 32'hF000_0000 | $urandom;
      b_arr[i] = 32'hF000_0000 | $urandom;
    end
    apply(4'h0, 1'b0, 64'hA5A5_0F0F_3C3C_1234, '0, "R9");
    apply(4'h5, 1'b0, 64'h0000_FFFF_0000_0001, '1, "R9");
  endtask

  task automatic t_idle();  // R10
    logic [L*32-1:0] snap_r;
    logic [L-1:0] snap_c;
    fill_rand();
    apply(4'h0, 1'b0, 64'h0123_4567_89AB_CDEF, '0, "R10");
    snap_r = res; snap_c = cout_mask;
    @(negedge clk);
    n_vec++;
    if (out_vld !== 1'b0 || wr_en !== '0 || res !== snap_r || cout_mask !== snap_c) begin
      $display("FAIL R10 idle cycle actual vld=%b wr=%h cout=%h expected 0/0/%h and held results",
               out_vld, wr_en, cout_mask, snap_c);
      n_bad++;
    end
  endtask

  task automatic t_badop();  // R12
    fill_rand();
    apply(4'h9, 1'b0, '1, '1, "R12");
    apply(4'hF, 1'b1, '1, '1, "R12");
  endtask

  initial begin
    for (int i = 0; i < L; i++) begin a_arr[i] = '0; b_arr[i] = '0; exp_res[i] = '0; end
    exp_cout = '0; exp_wr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_add32();
    t_addc();
    t_sub();
    t_subb();
    t_add16();
    t_sub16();
    t_inactive();
    t_idle();
    t_badop();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check_cleared("R11");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    $display("FAIL watchdog expired actual running expected done");
    n_bad++;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule